// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block holds the receive and transmit byte queues of a UART and derives four interrupt status flags from how full they are. The host side sees a byte-wide register port with two registers: a FIFO control register and a read-only interrupt status register. Host data moves through separate push and pop ports. The serial side has a push port for received bytes, a pop port for bytes to transmit, an idle indication from the transmit shifter and a one-cycle tick per character time.

Queue depth is 16 or 32 bytes, chosen by a static configuration pin. The trigger levels for both directions come from a two-bit code in the control register, and the table they use depends on that depth. The receive threshold flag also fires when data has sat below the trigger level for too long. The transmitter-empty flag stays set until the status register is read.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, rx_thresh_flag, rx_tout_flag and tx_empty_flag are 0, and tx_thresh_flag is 1.
- R2: The control register is reg_sel=0. Bit 0 is the FIFO enable, bit 1 resets the receive FIFO, bit 2 resets the transmit FIFO, bits 5:4 select the transmit level and bits 7:6 select the receive level. On readback, bits 3:1 are always 0.
- R3: With deep_mode=0 and the FIFOs enabled, receive codes 0,1,2,3 give trigger levels 1,4,8,14. rx_thresh_flag is 1 whenever the receive count is at or above the level, and it is seen in the cycle after the push edge.
- R4: With deep_mode=1, the same receive codes give levels 1,4,16,26.
- R5: rx_thresh_flag drops once host pops bring the receive count below the level, provided no timeout is pending.
- R6: When the receive FIFO is non-empty and four char_tick pulses arrive with no receive push and no host pop, rx_tout_flag and rx_thresh_flag are set at the edge of the fourth tick. Any push or pop restarts the count.
- R7: A host receive pop clears rx_tout_flag at that edge.
- R8: tx_thresh_flag is 1 while the transmit count is below the selected level. Transmit codes use the same tables as R3 and R4.
- R9: tx_empty_flag sets one cycle after the transmit FIFO is empty and tx_shift_idle is 1, if either was false the cycle before. A status register read clears it. A set in the same cycle wins over the clear.
- R10: Writing 1 to a FIFO reset bit empties only that FIFO at the write edge. The bit does not stay set.
- R11: Each FIFO keeps byte order, holds 16 or 32 bytes per deep_mode, and drops pushes made while full.
- R12: With the enable bit at 0, each FIFO holds one byte and both trigger levels are 1 whatever the codes. Any change of the enable bit empties both FIFOs.
- R13: The status register (reg_sel=1) reads rx_thresh_flag on bit 0, tx_thresh_flag on bit 1, tx_empty_flag on bit 2 and rx_tout_flag on bit 3, with 0 in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| deep_mode | input | 1 | 1 selects 32-byte FIFOs, 0 selects 16-byte FIFOs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_sel |
| host_tx_push | input | 1 | Host writes a byte to the transmit FIFO |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host reads a byte from the receive FIFO |
| host_rx_data | output | 8 | Head of the receive FIFO |
| ser_rx_push | input | 1 | Receive shifter delivers a byte |
| ser_rx_data | input | 8 | Received byte |
| ser_tx_pop | input | 1 | Transmit shifter takes a byte |
| ser_tx_data | output | 8 | Head of the transmit FIFO |
| tx_shift_idle | input | 1 | Transmit shifter holds no data |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_thresh_flag | output | 1 | Receive level reached, or a timeout is pending |
| rx_tout_flag | output | 1 | Receive timeout pending |
| tx_thresh_flag | output | 1 | Transmit count below its level |
| tx_empty_flag | output | 1 | Transmitter drained since the last status read |

## Verification
The assertions take deep_mode as static while either FIFO holds data. They also take char_tick as a single-cycle pulse and assume pops from an empty FIFO are harmless no-ops. The stimulus changes deep_mode only after every queue has been drained and reset, and it pulses char_tick for one cycle at a time. It issues pops only when the bench's own model counts data present, except where dropping is the behaviour under test. All inputs change at the falling edge, so every strobe covers exactly one rising edge.

// File: rtl/uart_fifo_irq_pkg.sv
// Package: shared constants, control register type and trigger-level table.
// Assumes levels never exceed the configured depth.
package uart_fifo_irq_pkg;

    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       en;
    } fifo_ctrl_t;

    // Maps a two-bit level code to a byte count; depth and enable pick the table.
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input logic deep,
                                               input logic en);
        if (!en) return 1;
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return deep ? 16 : 8;
            default: return deep ? 26 : 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
// Byte FIFO with a runtime capacity limit and a synchronous clear.
// Assumes DEPTH is a power of two. Pushes past cap are dropped, and pops
// from an empty FIFO do nothing.
module uart_byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              push_ok, pop_ok;

    assign push_ok = push && (count < cap);
    assign pop_ok  = pop && (count != '0);
    assign dout    = mem[rptr];

    // Pointer and occupancy update; clear has priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + PTR_W'(1);
            if (pop_ok)  rptr <= rptr + PTR_W'(1);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wptr] <= din;
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    a_r11_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count >= cap) |=> count == $past(count));
endmodule

// File: rtl/uart_rx_timeout.sv
// Receive timeout: counts character ticks while data waits in the FIFO with
// no traffic, and raises a sticky flag after CHARS ticks. Assumes char_tick
// lasts one cycle.
module uart_rx_timeout #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic nonempty,
    input  logic activity,
    input  logic host_pop,
    input  logic char_tick,
    output logic tout
);
    localparam int TMR_W = $clog2(CHARS + 1);

    logic [TMR_W-1:0] tmr;
    logic             expire;

    assign expire = nonempty && !activity && char_tick && (tmr == TMR_W'(CHARS - 1));

    // Idle character counter, restarted by any traffic or an empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !nonempty || activity) tmr <= '0;
        else if (char_tick && tmr != TMR_W'(CHARS - 1)) tmr <= tmr + TMR_W'(1);
    end

    // Sticky timeout flag, cleared by a host pop or a FIFO clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || host_pop) tout <= 1'b0;
        else if (expire)               tout <= 1'b1;
    end

    a_r6_tout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout) |-> $past(nonempty && char_tick));
    a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop |=> !tout);
endmodule

// File: rtl/uart_tx_empty_flag.sv
// Transmitter-empty flag: sets when the FIFO and shifter first both become
// empty, and is cleared by a status read. Reset counts as already reported.
module uart_tx_empty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic shift_idle,
    input  logic status_rd,
    output logic flag
);
    logic drained, drained_q;

    assign drained = fifo_empty && shift_idle;

    // Remembers the drained state of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) drained_q <= 1'b1;
        else        drained_q <= drained;
    end

    // Flag register: a new drain event wins over a same-cycle status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag <= 1'b0;
        else if (drained && !drained_q) flag <= 1'b1;
        else if (status_rd)             flag <= 1'b0;
    end

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !drained) |=> !flag);
    a_r9_set_needs_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(drained));
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
// Top: control/status registers, two byte FIFOs, level compare, receive
// timeout and transmitter-empty tracking. Assumes deep_mode changes only
// while both FIFOs are empty.
module uart_fifo_irq_ctrl
    import uart_fifo_irq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MAX_DEPTH  = 32,
    parameter int TOUT_CHARS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    input  logic              tx_shift_idle,
    input  logic              char_tick,
    output logic              rx_thresh_flag,
    output logic              rx_tout_flag,
    output logic              tx_thresh_flag,
    output logic              tx_empty_flag
);
    localparam int CNT_W = $clog2(MAX_DEPTH + 1);

    fifo_ctrl_t       ctrl_q;
    logic             wr_ctrl, en_change, rx_clr, tx_clr;
    logic [CNT_W-1:0] cap, rx_cnt, tx_cnt, rx_lvl, tx_lvl;
    logic             unused_wbit;

    assign unused_wbit = reg_wdata[3];
    assign wr_ctrl     = reg_wr && !reg_sel;
    assign en_change   = wr_ctrl && (reg_wdata[0] != ctrl_q.en);
    assign rx_clr      = (wr_ctrl && reg_wdata[1]) || en_change;
    assign tx_clr      = (wr_ctrl && reg_wdata[2]) || en_change;

    // Control register; the reset bits only strobe and are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= '{rx_sel: reg_wdata[7:6], tx_sel: reg_wdata[5:4], en: reg_wdata[0]};
    end

    // Capacity and trigger levels from the enable bit, depth pin and codes.
    always_comb begin
        cap    = !ctrl_q.en ? CNT_W'(1) : (deep_mode ? CNT_W'(MAX_DEPTH) : CNT_W'(MAX_DEPTH / 2));
        rx_lvl = CNT_W'(trig_level(ctrl_q.rx_sel, deep_mode, ctrl_q.en));
        tx_lvl = CNT_W'(trig_level(ctrl_q.tx_sel, deep_mode, ctrl_q.en));
    end

    uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
        .push(ser_rx_push), .din(ser_rx_data),
        .pop(host_rx_pop), .dout(host_rx_data), .count(rx_cnt));

    uart_byte_fifo #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH), .CNT_W(CNT_W)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
        .push(host_tx_push), .din(host_tx_data),
        .pop(ser_tx_pop), .dout(ser_tx_data), .count(tx_cnt));

    uart_rx_timeout #(.CHARS(TOUT_CHARS)) rx_tout_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .nonempty(rx_cnt != '0),
        .activity(ser_rx_push || host_rx_pop), .host_pop(host_rx_pop),
        .char_tick(char_tick), .tout(rx_tout_flag));

    uart_tx_empty_flag tx_empty_i (
        .clk(clk), .rst_n(rst_n), .fifo_empty(tx_cnt == '0),
        .shift_idle(tx_shift_idle), .status_rd(reg_rd && reg_sel),
        .flag(tx_empty_flag));

    assign rx_thresh_flag = (rx_cnt >= rx_lvl) || rx_tout_flag;
    assign tx_thresh_flag = tx_cnt < tx_lvl;

    // Register readback mux.
    always_comb begin
        if (reg_sel) reg_rdata = {4'b0, rx_tout_flag, tx_empty_flag, tx_thresh_flag, rx_thresh_flag};
        else         reg_rdata = {ctrl_q.rx_sel, ctrl_q.tx_sel, 3'b000, ctrl_q.en};
    end

    a_r3_rx_flag_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_thresh_flag |-> rx_cnt != '0);
    a_r12_disabled_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> (rx_cnt <= CNT_W'(1) && tx_cnt <= CNT_W'(1)));
    a_r12_enable_change_empties: assert property (@(posedge clk) disable iff (!rst_n)
        en_change |=> (rx_cnt == '0 && tx_cnt == '0));
endmodule

// File: tb/uart_fifo_irq_ctrl_tb_top.sv
module uart_fifo_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_mode = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       host_tx_push = 1'b0, host_rx_pop = 1'b0;
    logic [7:0] host_tx_data = '0, host_rx_data;
    logic       ser_rx_push = 1'b0, ser_tx_pop = 1'b0;
    logic [7:0] ser_rx_data = '0, ser_tx_data;
    logic       tx_shift_idle = 1'b1, char_tick = 1'b0;
    logic       rx_thresh_flag, rx_tout_flag, tx_thresh_flag, tx_empty_flag;

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    byte unsigned rxq[$], txq[$];
    bit m_en = 1'b0;
    int m_rx_code = 0, m_tx_code = 0;

    always #2 clk = ~clk;

    uart_fifo_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .tx_shift_idle(tx_shift_idle), .char_tick(char_tick),
        .rx_thresh_flag(rx_thresh_flag), .rx_tout_flag(rx_tout_flag),
        .tx_thresh_flag(tx_thresh_flag), .tx_empty_flag(tx_empty_flag));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cap_m();
        if (!m_en) return 1;
        return deep_mode ? 32 : 16;
    endfunction

    function automatic int lvl_m(input int code);
        if (!m_en) return 1;
        case (code)
            0: return 1;
            1: return 4;
            2: return deep_mode ? 16 : 8;
            default: return deep_mode ? 26 : 14;
        endcase
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wctrl(input logic [7:0] d);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (d[1] || d[0] != m_en) rxq.delete();
        if (d[2] || d[0] != m_en) txq.delete();
        m_en = d[0]; m_rx_code = d[7:6]; m_tx_code = d[5:4];
    endtask

    task automatic rd_status(output logic [7:0] v);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_sel = 1'b0;
    endtask

    // Driver: serial side delivers a byte; expected copy queued if it fits.
    task automatic rx_push(input byte unsigned b);
        ser_rx_push = 1'b1; ser_rx_data = b;
        if (rxq.size() < cap_m()) rxq.push_back(b);
        @(negedge clk);
        ser_rx_push = 1'b0;
    endtask

    // Monitor: host pops and compares with the scoreboard head.
    task automatic rx_pop();
        if (rxq.size() > 0) chk("R11 rx byte order", host_rx_data, rxq.pop_front());
        host_rx_pop = 1'b1;
        @(negedge clk);
        host_rx_pop = 1'b0;
    endtask

    task automatic tx_push(input byte unsigned b);
        host_tx_push = 1'b1; host_tx_data = b;
        if (txq.size() < cap_m()) txq.push_back(b);
        @(negedge clk);
        host_tx_push = 1'b0;
    endtask

    task automatic tx_pop();
        if (txq.size() > 0) chk("R11 tx byte order", ser_tx_data, txq.pop_front());
        ser_tx_pop = 1'b1;
        @(negedge clk);
        ser_tx_pop = 1'b0;
    endtask

    task automatic tick();
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    task automatic rx_level_sweep(input string req);
        for (int code = 0; code < 4; code++) begin
            wctrl(8'(code << 6) | 8'h01);
            for (int i = 1; i <= lvl_m(code); i++) begin
                rx_push(8'(i * 7 + code));
                chk(req, rx_thresh_flag, (i >= lvl_m(code)) ? 1 : 0);
            end
            while (rxq.size() > 0) begin
                rx_pop();
                chk("R5 rx flag after pop", rx_thresh_flag, (rxq.size() >= lvl_m(code)) ? 1 : 0);
            end
        end
    endtask

    task automatic tx_level_sweep();
        for (int code = 0; code < 4; code++) begin
            wctrl(8'(code << 4) | 8'h01);
            for (int i = 1; i <= lvl_m(code); i++) begin
                tx_push(8'(i + 100));
                chk("R8 tx flag on push", tx_thresh_flag, (i < lvl_m(code)) ? 1 : 0);
            end
            while (txq.size() > 0) begin
                tx_pop();
                chk("R8 tx flag on pop", tx_thresh_flag, (txq.size() < lvl_m(code)) ? 1 : 0);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 ctrl reads zero", reg_rdata, 0);
        chk("R1 rx_thresh", rx_thresh_flag, 0);
        chk("R1 rx_tout", rx_tout_flag, 0);
        chk("R1 tx_empty", tx_empty_flag, 0);
        chk("R1 tx_thresh", tx_thresh_flag, 1);
        rd_status(st);
        chk("R13 status after reset", st, 8'h02);

        // R2 layout and readback
        wctrl(8'hFF);
        chk("R2 readback masks bits 3:1", reg_rdata, 8'hF1);
        wctrl(8'h01);

        // R3 and R5 in 16-byte mode
        rx_level_sweep("R3 rx level 16-byte");
        // R8 transmit levels in 16-byte mode
        tx_level_sweep();

        // R4 in 32-byte mode
        deep_mode = 1'b1;
        rx_level_sweep("R4 rx level 32-byte");
        tx_level_sweep();

        // R11 capacity 32 and drop when full
        wctrl(8'h01);
        for (int i = 0; i < 33; i++) rx_push(8'(i + 1));
        chk("R11 holds 32", rxq.size(), 32);
        while (rxq.size() > 0) rx_pop();
        chk("R11 empty after 32 pops", rx_thresh_flag, 0);

        // R11 capacity 16
        deep_mode = 1'b0;
        for (int i = 0; i < 17; i++) rx_push(8'(i + 50));
        while (rxq.size() > 0) rx_pop();
        chk("R11 extra push dropped at 16", rx_thresh_flag, 0);

        // R6 and R7 timeout, level 8
        wctrl(8'h81);
        rx_push(8'hA1); rx_push(8'hA2);
        tick(); tick(); tick();
        chk("R6 no timeout after 3 ticks", rx_tout_flag, 0);
        rx_push(8'hA3);
        tick(); tick(); tick();
        chk("R6 push restarts timer", rx_tout_flag, 0);
        tick();
        chk("R6 timeout after 4 ticks", rx_tout_flag, 1);
        chk("R6 rx_thresh on timeout", rx_thresh_flag, 1);
        rd_status(st);
        chk("R13 status rx bits", st & 8'h09, 8'h09);
        rx_pop();
        chk("R7 pop clears timeout", rx_tout_flag, 0);
        chk("R5 rx_thresh below level", rx_thresh_flag, 0);
        tick(); tick(); tick();
        rx_pop();
        tick(); tick(); tick();
        chk("R6 pop restarts timer", rx_tout_flag, 0);
        rx_pop();
        tick(); tick(); tick(); tick(); tick();
        chk("R6 empty fifo no timeout", rx_tout_flag, 0);

        // R9 transmitter empty
        rd_status(st);
        chk("R9 flag cleared by read", tx_empty_flag, 0);
        tx_push(8'h5A);
        tx_pop();
        chk("R9 not yet set", tx_empty_flag, 0);
        cyc(1);
        chk("R9 set after drain", tx_empty_flag, 1);
        rd_status(st);
        chk("R13 status tx_empty bit", st[2], 1);
        chk("R9 read clears", tx_empty_flag, 0);
        tx_push(8'h5B);
        tx_shift_idle = 1'b0;
        tx_pop();
        cyc(2);
        chk("R9 busy shifter holds off", tx_empty_flag, 0);
        tx_shift_idle = 1'b1;
        cyc(1);
        chk("R9 set when shifter idles", tx_empty_flag, 1);
        rd_status(st);

        // R10 FIFO reset bits
        wctrl(8'h01);
        rx_push(8'hC0); rx_push(8'hC1); rx_push(8'hC2);
        tx_push(8'hD0); tx_push(8'hD1);
        wctrl(8'h03);
        chk("R10 rx reset empties rx", rx_thresh_flag, 0);
        chk("R10 reset bit reads zero", reg_rdata, 8'h01);
        tx_pop(); tx_pop();
        tx_push(8'hD2);
        wctrl(8'h05);
        chk("R10 tx reset empties tx", tx_thresh_flag, 1);
        rx_push(8'hC3);
        chk("R10 rx unaffected by tx reset", rx_thresh_flag, 1);
        rx_pop();

        // R12 disabled mode
        rx_push(8'hE0);
        wctrl(8'h00);
        chk("R12 enable change empties rx", rx_thresh_flag, 0);
        rx_push(8'hE1); rx_push(8'hE2);
        chk("R12 one byte triggers", rx_thresh_flag, 1);
        rx_pop();
        chk("R12 second byte dropped", rx_thresh_flag, 0);
        tx_push(8'hF0); tx_push(8'hF1);
        chk("R12 tx level one", tx_thresh_flag, 0);
        tx_pop();
        chk("R12 tx single byte", tx_thresh_flag, 1);
        wctrl(8'hC0);
        rx_push(8'h11);
        chk("R12 code ignored when disabled", rx_thresh_flag, 1);
        rx_pop();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule